// File: doc/BRIEF.md
# PWM Output Compare Channel

This block is a single output-compare channel that sits beside a shared time base. Every clock it receives the current count value and the count direction, along with strobes that mark overflow, underflow and the update event, and a trigger input. From these and a small configuration word it produces one registered reference level and a one-clock compare-match strobe. The channel supports compare-driven set, clear and toggle modes, two forced levels, two edge or centre PWM shapes, and two asymmetric PWM shapes. In the asymmetric shapes the falling half of a centre-aligned period compares against a second, alternate compare value.

Both compare values can be written directly, or through a preload shadow that is copied into the active value only on the update event. An immediate-active option lets a trigger force the reference high at once in the two plain PWM modes. That forced phase ends by itself at the next overflow or underflow strobe. The asymmetric modes are meaningful only when the time base counts up and down (centre-aligned). The channel trusts its user on this and does not check it.

Top module: `pwm_cmp_chan`

## Requirements
- R1: While reset is asserted and on the first clock after it, ref_o and match_o are 0, and the mode, preload flag, immediate flag and both compare values are 0.
- R2: A configuration write takes mode bits 2:0 from cfg_wdata[2:0], mode bit 3 from cfg_wdata[8], the preload flag from cfg_wdata[4] and the immediate flag from cfg_wdata[5]. The new mode governs ref_o from the clock after the clock that stores the write.
- R3: In mode 0000, and in the unused codes 1000 through 1101, ref_o keeps its value.
- R4: In a cycle where cnt equals the selected compare value, ref_o on the next clock becomes 0 in mode 0001, 1 in mode 0010, and the inverse of its value in mode 0011. In cycles without a match, these modes hold ref_o.
- R5: Mode 0100 drives ref_o to 0 and mode 0101 drives it to 1 on the next clock, whatever the count.
- R6: Mode 0110 sets ref_o on the next clock to (cnt < compare) when cnt_down is 0, and to (cnt <= compare) when cnt_down is 1.
- R7: Mode 0111 gives the inverse of the mode 0110 level in both directions.
- R8: Modes 1110 and 1111 behave as 0110 and 0111. The difference is that while cnt_down is 1 they use the alternate compare value, and while counting up they use the main one.
- R9: With the preload flag at 0, a compare write becomes the active value on the same clock. With the flag at 1, the write goes to a shadow. The active value then changes only on a clock where upd_evt is 1, and it takes the shadow contents held before that clock. This rule applies to both the main and the alternate compare values.
- R10: match_o is 1 for exactly the clock following each cycle in which cnt equals the selected compare value.
- R11: In mode 0110 or 0111 with the immediate flag set, a trigger drives ref_o to 1 from the next clock. It stays 1 until the clock after a cycle with ovf_evt or udf_evt and no trigger. A trigger in the same cycle as such a strobe starts or extends the forced phase.
- R12: The immediate flag and trig have no effect on ref_o in any mode other than 0110 and 0111, including the asymmetric modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 9 | Configuration word (mode, preload flag, immediate flag) |
| cmp_we | input | 1 | Main compare value write strobe |
| cmp_wdata | input | CNT_W | Main compare write data |
| alt_we | input | 1 | Alternate compare value write strobe |
| alt_wdata | input | CNT_W | Alternate compare write data |
| cnt | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| upd_evt | input | 1 | Update event strobe |
| ovf_evt | input | 1 | Overflow strobe |
| udf_evt | input | 1 | Underflow strobe |
| trig | input | 1 | Trigger for the immediate-active phase |
| ref_o | output | 1 | Registered reference level |
| match_o | output | 1 | One-clock compare-match strobe |

## Verification
The bench runs the channel against two count patterns: a wrapping up-count and a centre-aligned up/down count. The up-count alone cannot show the down-half rule of R6, or whether the asymmetric modes switch to the alternate value when the direction flips. The centre-aligned pattern also runs with compare values of 0 and the peak count, where the strict and non-strict comparisons give different results. Separate stretches cover three other cases. Preload writes are placed mid-period, which exposes a compare value that is taken early. Triggers are pulsed at many phases of the count, so some coincide with overflow and underflow strobes. The same trigger pattern is repeated in modes that must ignore it.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

   localparam int CFG_W        = 9;
   localparam int CFG_MODE_LO  = 0;
   localparam int CFG_MODE_HI  = 8;
   localparam int CFG_PRE_BIT  = 4;
   localparam int CFG_IMM_BIT  = 5;

   localparam logic [3:0] OM_HOLD  = 4'b0000;
   localparam logic [3:0] OM_CLR   = 4'b0001;
   localparam logic [3:0] OM_SET   = 4'b0010;
   localparam logic [3:0] OM_TOG   = 4'b0011;
   localparam logic [3:0] OM_LO    = 4'b0100;
   localparam logic [3:0] OM_HI    = 4'b0101;
   localparam logic [3:0] OM_PWM_A = 4'b0110;
   localparam logic [3:0] OM_PWM_B = 4'b0111;
   localparam logic [3:0] OM_ASY_A = 4'b1110;
   localparam logic [3:0] OM_ASY_B = 4'b1111;

   typedef struct packed {
      logic       imm;
      logic       pre;
      logic [3:0] mode;
   } oc_cfg_t;

   function automatic oc_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
      oc_cfg_t c;
      c.mode = {w[CFG_MODE_HI], w[CFG_MODE_LO+2:CFG_MODE_LO]};
      c.pre  = w[CFG_PRE_BIT];
      c.imm  = w[CFG_IMM_BIT];
      return c;
   endfunction

   function automatic logic is_plain_pwm(input logic [3:0] m);
      return (m == OM_PWM_A) || (m == OM_PWM_B);
   endfunction

   function automatic logic is_asym(input logic [3:0] m);
      return (m == OM_ASY_A) || (m == OM_ASY_B);
   endfunction

endpackage

// File: rtl/pwm_cmp_store.sv
module pwm_cmp_store #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pre,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         upd,
   output logic [W-1:0] act
);
   logic [W-1:0] shadow_q;
   logic [W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         act_q    <= '0;
      end else begin
         if (wr)
            shadow_q <= wdata;
         if (wr && !pre)
            act_q <= wdata;
         else if (pre && upd)
            act_q <= shadow_q;
      end
   end

   assign act = act_q;
endmodule

// File: rtl/pwm_cmp_imm.sv
module pwm_cmp_imm (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic trig,
   input  logic stop,
   output logic force_now
);
   logic force_q;

   assign force_now = arm && (trig || (force_q && !stop));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         force_q <= 1'b0;
      else
         force_q <= force_now;
   end
endmodule

// File: rtl/pwm_cmp_ref.sv
module pwm_cmp_ref
   import pwm_cmp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [3:0]   mode,
   input  logic [W-1:0] cnt,
   input  logic         down,
   input  logic [W-1:0] cmp_main,
   input  logic [W-1:0] cmp_alt,
   input  logic         force_now,
   output logic         ref_o,
   output logic         match_o
);
   logic [W-1:0] sel;
   logic         hit;
   logic         lvl_a;
   logic         ref_q;
   logic         ref_d;
   logic         match_q;

   assign sel   = (is_asym(mode) && down) ? cmp_alt : cmp_main;
   assign hit   = (cnt == sel);
   assign lvl_a = down ? (cnt <= sel) : (cnt < sel);

   always_comb begin
      ref_d = ref_q;
      case (mode)
         OM_CLR:             if (hit) ref_d = 1'b0;
         OM_SET:             if (hit) ref_d = 1'b1;
         OM_TOG:             if (hit) ref_d = !ref_q;
         OM_LO:              ref_d = 1'b0;
         OM_HI:              ref_d = 1'b1;
         OM_PWM_A, OM_ASY_A: ref_d = force_now ? 1'b1 : lvl_a;
         OM_PWM_B, OM_ASY_B: ref_d = force_now ? 1'b1 : !lvl_a;
         default:            ref_d = ref_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= 1'b0;
         match_q <= 1'b0;
      end else begin
         ref_q   <= ref_d;
         match_q <= hit;
      end
   end

   assign ref_o   = ref_q;
   assign match_o = match_q;
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
   import pwm_cmp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [8:0]       cfg_wdata,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             alt_we,
   input  logic [CNT_W-1:0] alt_wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_down,
   input  logic             upd_evt,
   input  logic             ovf_evt,
   input  logic             udf_evt,
   input  logic             trig,
   output logic             ref_o,
   output logic             match_o
);
   localparam int NSLOT = 2;

   initial begin : p_param_chk
      if (CNT_W < 2 || CNT_W > 32)
         $fatal(1, "pwm_cmp_chan: CNT_W out of range");
   end

   oc_cfg_t    cfg_q;
   logic [3:0] mode_q;
   logic       pre_q;
   logic       imm_q;
   logic       unused_rsvd;

   assign unused_rsvd = ^{cfg_wdata[7:6], cfg_wdata[3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (cfg_we)
         cfg_q <= unpack_cfg(cfg_wdata);
   end

   assign mode_q = cfg_q.mode;
   assign pre_q  = cfg_q.pre;
   assign imm_q  = cfg_q.imm;

   logic [NSLOT-1:0]            slot_we;
   logic [NSLOT-1:0][CNT_W-1:0] slot_wd;
   logic [NSLOT-1:0][CNT_W-1:0] slot_act;

   assign slot_we    = {alt_we, cmp_we};
   assign slot_wd[0] = cmp_wdata;
   assign slot_wd[1] = alt_wdata;

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      pwm_cmp_store #(.W(CNT_W)) u_store (
         .clk   (clk),
         .rst_n (rst_n),
         .pre   (pre_q),
         .wr    (slot_we[g]),
         .wdata (slot_wd[g]),
         .upd   (upd_evt),
         .act   (slot_act[g])
      );
   end

   logic [CNT_W-1:0] cmp_main;
   logic [CNT_W-1:0] cmp_alt;
   logic             force_now;

   assign cmp_main = slot_act[0];
   assign cmp_alt  = slot_act[1];

   pwm_cmp_imm u_imm (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (imm_q && is_plain_pwm(mode_q)),
      .trig      (trig),
      .stop      (ovf_evt || udf_evt),
      .force_now (force_now)
   );

   pwm_cmp_ref #(.W(CNT_W)) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .cnt       (cnt),
      .down      (cnt_down),
      .cmp_main  (cmp_main),
      .cmp_alt   (cmp_alt),
      .force_now (force_now),
      .ref_o     (ref_o),
      .match_o   (match_o)
   );
endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       mode_q,
   input logic             pre_q,
   input logic             imm_q,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_down,
   input logic             trig,
   input logic             upd_evt,
   input logic [CNT_W-1:0] cmp_main,
   input logic             ref_o,
   input logic             match_o
);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!ref_o && !match_o));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 4'b0000 || (mode_q[3] && mode_q[3:1] != 3'b111)) |=> $stable(ref_o));

   assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 4'b0011 && cnt == cmp_main) |=> (ref_o != $past(ref_o)));

   assert_force_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 4'b0100) |=> !ref_o);

   assert_force_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 4'b0101) |=> ref_o);

   assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_q && !upd_evt) |=> $stable(cmp_main));

   assert_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_down && cnt == cmp_main) |=> match_o);

   assert_imm_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_q && trig && (mode_q == 4'b0110 || mode_q == 4'b0111)) |=> ref_o);
endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_q   (mode_q),
   .pre_q    (pre_q),
   .imm_q    (imm_q),
   .cnt      (cnt),
   .cnt_down (cnt_down),
   .trig     (trig),
   .upd_evt  (upd_evt),
   .cmp_main (cmp_main),
   .ref_o    (ref_o),
   .match_o  (match_o)
);

// File: tb/pwm_cmp_chan_tb.sv
`timescale 1ns/1ps
module pwm_cmp_chan_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [8:0]   cfg_wdata = '0;
   logic         cmp_we = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic         alt_we = 1'b0;
   logic [W-1:0] alt_wdata = '0;
   logic [W-1:0] cnt = '0;
   logic         cnt_down = 1'b0;
   logic         upd_evt = 1'b0;
   logic         ovf_evt = 1'b0;
   logic         udf_evt = 1'b0;
   logic         trig = 1'b0;
   logic         ref_o;
   logic         match_o;

   always #2.5 clk = ~clk;

   pwm_cmp_chan #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .alt_we(alt_we), .alt_wdata(alt_wdata),
      .cnt(cnt), .cnt_down(cnt_down), .upd_evt(upd_evt), .ovf_evt(ovf_evt),
      .udf_evt(udf_evt), .trig(trig), .ref_o(ref_o), .match_o(match_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   // time base driver
   int style = 0;      // 0 up-count wrap, 1 centre-aligned
   int period = 15;
   bit upd_auto = 0;

   always @(negedge clk) begin
      int c;
      c = int'(cnt);
      if (style == 0) begin
         c = (c >= period) ? 0 : c + 1;
         cnt_down <= 1'b0;
         ovf_evt  <= (c == period);
         udf_evt  <= 1'b0;
      end else begin
         if (!cnt_down) begin
            c = c + 1;
            if (c >= period) cnt_down <= 1'b1;
         end else begin
            c = c - 1;
            if (c <= 0) cnt_down <= 1'b0;
         end
         ovf_evt <= (c == period);
         udf_evt <= (c == 0);
      end
      upd_evt <= upd_auto && ((c == period) || (style == 1 && c == 0));
      cnt     <= W'(c);
   end

   // reference model
   int m_mode, m_cmp, m_buf, m_alt, m_abuf;
   bit m_pre, m_imm, m_ref, m_match, m_force;

   always @(posedge clk) begin
      int sel, c;
      bit hit, lvl, armed, frc, nref;
      if (!rst_n) begin
         m_mode = 0; m_cmp = 0; m_buf = 0; m_alt = 0; m_abuf = 0;
         m_pre = 0; m_imm = 0; m_ref = 0; m_match = 0; m_force = 0;
      end else begin
         c     = int'(cnt);
         sel   = ((m_mode == 14 || m_mode == 15) && cnt_down) ? m_alt : m_cmp;
         hit   = (c == sel);
         lvl   = cnt_down ? (c <= sel) : (c < sel);
         armed = m_imm && (m_mode == 6 || m_mode == 7);
         frc   = armed && (trig || (m_force && !(ovf_evt || udf_evt)));
         nref  = m_ref;
         case (m_mode)
            1: if (hit) nref = 0;
            2: if (hit) nref = 1;
            3: if (hit) nref = !m_ref;
            4: nref = 0;
            5: nref = 1;
            6, 14: nref = frc ? 1'b1 : lvl;
            7, 15: nref = frc ? 1'b1 : !lvl;
            default: nref = m_ref;
         endcase
         m_ref   = nref;
         m_match = hit;
         m_force = frc;
         if (m_pre && upd_evt) begin
            m_cmp = m_buf;
            m_alt = m_abuf;
         end
         if (cmp_we) begin
            m_buf = int'(cmp_wdata);
            if (!m_pre) m_cmp = int'(cmp_wdata);
         end
         if (alt_we) begin
            m_abuf = int'(alt_wdata);
            if (!m_pre) m_alt = int'(alt_wdata);
         end
         if (cfg_we) begin
            m_mode = {cfg_wdata[8], cfg_wdata[2:0]};
            m_pre  = cfg_wdata[4];
            m_imm  = cfg_wdata[5];
         end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         n_chk++;
         if (ref_o !== m_ref) begin
            n_bad++;
            $display("FAIL %s ref_o at %0t: got %b expected %b", cur_req, $time, ref_o, m_ref);
         end
         n_chk++;
         if (match_o !== m_match) begin
            n_bad++;
            $display("FAIL R10 match_o at %0t: got %b expected %b", $time, match_o, m_match);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R2 field layout: mode[2:0]->bits 2:0, mode[3]->bit 8, preload bit 4, immediate bit 5
   task automatic set_cfg(input logic [3:0] m, input bit pre, input bit imm);
      @(negedge clk);
      cfg_we    <= 1'b1;
      cfg_wdata <= {m[3], 2'b00, imm, pre, 1'b0, m[2:0]};
      @(negedge clk);
      cfg_we    <= 1'b0;
   endtask

   task automatic set_cmp(input int v, input bit alt);
      @(negedge clk);
      if (alt) begin alt_we <= 1'b1; alt_wdata <= W'(v); end
      else     begin cmp_we <= 1'b1; cmp_wdata <= W'(v); end
      @(negedge clk);
      alt_we <= 1'b0;
      cmp_we <= 1'b0;
   endtask

   task automatic trig_train(input int n, input int gap);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         trig <= 1'b1;
         @(negedge clk);
         trig <= 1'b0;
         idle(gap + (k % 5));
      end
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired: got hung run expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      cur_req = "R1";
      idle(3);
      rst_n <= 1'b1;
      idle(4);

      cur_req = "R4";
      set_cmp(5, 0);
      set_cfg(4'b0010, 0, 0); idle(20);
      set_cfg(4'b0001, 0, 0); idle(20);
      set_cfg(4'b0011, 0, 0); idle(40);

      cur_req = "R3";
      set_cfg(4'b0000, 0, 0); idle(20);
      set_cfg(4'b0101, 0, 0); idle(2);
      set_cfg(4'b1001, 0, 0); idle(20);
      set_cfg(4'b1101, 0, 0); idle(20);

      cur_req = "R5";
      set_cfg(4'b0100, 0, 0); idle(12);
      set_cfg(4'b0101, 0, 0); idle(12);

      cur_req = "R6";
      set_cfg(4'b0110, 0, 0); idle(40);
      style = 1; period = 12;
      idle(60);
      set_cmp(0, 0); idle(50);
      set_cmp(12, 0); idle(50);

      cur_req = "R7";
      set_cmp(7, 0);
      set_cfg(4'b0111, 0, 0); idle(60);
      style = 0; period = 15;
      idle(40);

      cur_req = "R8";
      style = 1; period = 12;
      set_cmp(9, 0);
      set_cmp(3, 1);
      set_cfg(4'b1110, 0, 0); idle(60);
      set_cfg(4'b1111, 0, 0); idle(60);

      cur_req = "R2";
      set_cfg(4'b0110, 0, 0); idle(1);
      set_cfg(4'b1110, 0, 0); idle(30);

      cur_req = "R9";
      upd_auto = 1;
      set_cfg(4'b1110, 1, 0);
      idle(5);
      set_cmp(4, 0); idle(3);
      set_cmp(10, 1); idle(40);
      set_cmp(8, 0); set_cmp(2, 0); idle(40);
      set_cfg(4'b1110, 0, 0);
      idle(5);
      set_cmp(6, 0); idle(3);
      set_cmp(5, 1); idle(30);
      upd_auto = 0;

      cur_req = "R11";
      set_cmp(6, 0);
      set_cfg(4'b0110, 0, 1);
      trig_train(12, 4);
      idle(30);
      set_cfg(4'b0111, 0, 1);
      trig_train(12, 6);
      idle(30);
      style = 0; period = 15;
      set_cfg(4'b0110, 0, 1);
      trig_train(10, 9);
      idle(20);

      cur_req = "R12";
      style = 1; period = 12;
      set_cfg(4'b0011, 0, 1);
      trig_train(10, 3);
      set_cfg(4'b1110, 0, 1);
      trig_train(10, 3);
      set_cfg(4'b0000, 0, 1);
      trig_train(6, 3);
      set_cfg(4'b0110, 0, 0);
      trig_train(8, 3);
      idle(10);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule